// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface Decoder

This block is the host-facing register port of a graphics display controller. One set of bus pins (chip select, address bit, two control pins and an 8-bit data bus) is read in one of two ways, picked by a static mode input. In strobe mode the two control pins are separate active-low read and write strobes. In enable mode one pin is a read/write level and the other is an active-high enable. Either way, each access becomes one of four operations: status read, data/cursor read, parameter write or command write.

Reads are answered straight from the pins, with no clock in the path. A status read returns a byte whose bit 6 follows the display retrace input. A data read returns the core's read word. The write path takes the bus controls and data through a two-flop synchronizer into the core clock domain. When a write ends, the block issues a one-cycle strobe carrying the written byte.

The block also keeps a sleep flag. The sleep command code sets it and the system-setup code clears it. While the flag is set, every other command code is dropped, along with the parameter bytes that follow a dropped command. No access ever waits: there is no ready or wait output. The host polls bit 6 of the status byte to time its writes.

Top module: `hbi_decoder`

## Requirements
- R1: With bus_mode=0 (strobe mode), chip select low, bus_wr low and bus_rd high is a write. bus_a0=0 makes it a parameter write and bus_a0=1 a command write. After bus_wr rises, exactly one one-cycle par_stb or cmd_stb follows, carrying the bus_din byte held during the write.
- R2: With bus_mode=1 (enable mode), chip select low, bus_wr (enable) high and bus_rd (read/write level) low is a write. bus_a0 chooses parameter (0) or command (1). The strobe follows the fall of the enable.
- R3: In strobe mode, chip select low, bus_rd low and bus_wr high drives bus_doe high. bus_dout is the status byte when bus_a0=0 and core_rdata when bus_a0=1. The end of a data read (bus_a0=1) gives one drd_stb pulse.
- R4: In enable mode, chip select low with both bus_wr and bus_rd high is a read, with the same bus_a0 selection and outputs as R3.
- R5: The status byte has bit 6 equal to retrace and every other bit 0.
- R6: With bus_cs_n high, bus_doe stays low and no strobe is produced, whatever the other pins do.
- R7: In strobe mode, bus_rd and bus_wr low together is no operation: bus_doe stays low and no strobe follows.
- R8: Command code 0x53 sets asleep and code 0x40 clears it. While asleep is set, only those two codes produce cmd_stb; any other command code is dropped.
- R9: After a dropped command, parameter writes produce no par_stb until the next accepted command.
- R10: cmd_stb, par_stb and drd_stb are each one cycle wide, and at most one of them is high in any cycle.
- R11: After reset, asleep is 0, bus_doe is low and no strobe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Static bus style: 0 strobe mode, 1 enable mode |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_a0 | input | 1 | Address bit choosing the operation pair |
| bus_rd | input | 1 | Read strobe (active low) or read/write level (1 = read) |
| bus_wr | input | 1 | Write strobe (active low) or enable (active high) |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data to the host |
| bus_doe | output | 1 | High while bus_dout must drive the bus |
| retrace | input | 1 | Display retrace state from the timing core |
| core_rdata | input | 8 | Data/cursor read word from the core |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command code, valid with cmd_stb |
| par_stb | output | 1 | One-cycle parameter/data strobe |
| par_data | output | 8 | Parameter byte, valid with par_stb |
| drd_stb | output | 1 | One-cycle pulse at the end of a data read |
| asleep | output | 1 | Sleep flag |

## Verification
Some properties are checked on every cycle. Bus_doe never rises while chip select is high, or while both strobes are low in strobe mode. A driven status byte carries nothing outside bit 6. The strobes are single-cycle and never coincide. No forwarded command breaks the sleep filter, and a forwarded sleep code always leaves asleep set.

Other behaviour only the bench's scenarios can show. These are the mapping of each pin pattern to the right operation in both bus styles, the captured byte values, and the discarding of parameters after a dropped command.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CODE_SYSSET = 8'h40;
    localparam logic [DATA_W-1:0] CODE_SLEEP  = 8'h53;
    localparam int                RETRACE_BIT = 6;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_STAT = 3'd1,
        OP_DRD  = 3'd2,
        OP_PWR  = 3'd3,
        OP_CWR  = 3'd4
    } op_e;

    typedef enum logic {
        MODE_STROBE = 1'b0,
        MODE_ENABLE = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic              cs_n;
        logic              a0;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] d;
    } bus_smp_t;

    // Map one pin pattern onto an operation for the chosen bus style.
    function automatic op_e decode_op(input bus_mode_e mode, input logic cs_n,
                                      input logic a0, input logic rd, input logic wr);
        op_e op;
        op = OP_NONE;
        if (!cs_n) begin
            if (mode == MODE_STROBE) begin
                if (!rd && wr)      op = a0 ? OP_DRD : OP_STAT;
                else if (rd && !wr) op = a0 ? OP_CWR : OP_PWR;
                else                op = OP_NONE;
            end else begin
                if (wr) op = rd ? (a0 ? OP_DRD : OP_STAT)
                                : (a0 ? OP_CWR : OP_PWR);
            end
        end
        return op;
    endfunction

    function automatic logic cmd_allowed(input logic sleeping, input logic [DATA_W-1:0] code);
        return !sleeping || (code == CODE_SYSSET) || (code == CODE_SLEEP);
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic rt);
        logic [DATA_W-1:0] s;
        s = '0;
        s[RETRACE_BIT] = rt;
        return s;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= '1;
                    else     stage_q[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= '1;
                    else     stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hbi_rdpath.sv
module hbi_rdpath
    import hbi_pkg::*;
(
    input  bus_mode_e         mode,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd,
    input  logic              wr,
    input  logic              retrace,
    input  logic [DATA_W-1:0] core_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);
    op_e raw_op;

    always_comb begin
        raw_op = decode_op(mode, cs_n, a0, rd, wr);
        doe    = (raw_op == OP_STAT) || (raw_op == OP_DRD);
        case (raw_op)
            OP_STAT: dout = status_byte(retrace);
            OP_DRD:  dout = core_rdata;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/hbi_wrgate.sv
module hbi_wrgate
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               cur_op,
    input  logic [DATA_W-1:0] cur_d,
    output logic              cmd_stb,
    output logic [DATA_W-1:0] cmd_code,
    output logic              par_stb,
    output logic [DATA_W-1:0] par_data,
    output logic              drd_stb,
    output logic              asleep
);
    op_e               prev_op;
    logic [DATA_W-1:0] prev_d;
    logic              par_ok;
    logic              op_end;

    assign op_end = (prev_op != cur_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_op <= OP_NONE;
            prev_d  <= '0;
        end else begin
            prev_op <= cur_op;
            prev_d  <= cur_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb  <= 1'b0;
            par_stb  <= 1'b0;
            drd_stb  <= 1'b0;
            cmd_code <= '0;
            par_data <= '0;
            par_ok   <= 1'b1;
            asleep   <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            par_stb <= 1'b0;
            drd_stb <= 1'b0;
            if (op_end) begin
                case (prev_op)
                    OP_CWR: begin
                        if (cmd_allowed(asleep, prev_d)) begin
                            cmd_stb  <= 1'b1;
                            cmd_code <= prev_d;
                            par_ok   <= 1'b1;
                            if (prev_d == CODE_SLEEP)  asleep <= 1'b1;
                            if (prev_d == CODE_SYSSET) asleep <= 1'b0;
                        end else begin
                            par_ok <= 1'b0;
                        end
                    end
                    OP_PWR: begin
                        if (par_ok) begin
                            par_stb  <= 1'b1;
                            par_data <= prev_d;
                        end
                    end
                    OP_DRD:  drd_stb <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb); // R10
    AST_PAR_PULSE: assert property (@(posedge clk) disable iff (rst)
        par_stb |=> !par_stb); // R10
    AST_SLEEP_FILTER: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && $past(asleep)) |-> (cmd_code == CODE_SYSSET || cmd_code == CODE_SLEEP)); // R8
    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_code == CODE_SLEEP) |-> asleep); // R8
endmodule

// File: rtl/hbi_decoder.sv
module hbi_decoder
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_mode,
    input  logic              bus_cs_n,
    input  logic              bus_a0,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic              retrace,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              cmd_stb,
    output logic [DATA_W-1:0] cmd_code,
    output logic              par_stb,
    output logic [DATA_W-1:0] par_data,
    output logic              drd_stb,
    output logic              asleep
);
    localparam int SMP_W = $bits(bus_smp_t);

    bus_mode_e mode;
    bus_smp_t  raw_smp;
    bus_smp_t  sync_smp;
    op_e       sync_op;

    assign mode    = bus_mode_e'(bus_mode);
    assign raw_smp = '{cs_n: bus_cs_n, a0: bus_a0, rd: bus_rd, wr: bus_wr, d: bus_din};

    hbi_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_smp),
        .dout (sync_smp)
    );

    assign sync_op = decode_op(mode, sync_smp.cs_n, sync_smp.a0, sync_smp.rd, sync_smp.wr);

    hbi_rdpath u_rd (
        .mode       (mode),
        .cs_n       (bus_cs_n),
        .a0         (bus_a0),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .retrace    (retrace),
        .core_rdata (core_rdata),
        .dout       (bus_dout),
        .doe        (bus_doe)
    );

    hbi_wrgate u_wr (
        .clk      (clk),
        .rst      (rst),
        .cur_op   (sync_op),
        .cur_d    (sync_smp.d),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code),
        .par_stb  (par_stb),
        .par_data (par_data),
        .drd_stb  (drd_stb),
        .asleep   (asleep)
    );

    AST_NO_DRIVE_DESEL: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> !bus_doe); // R6
    AST_BOTH_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && !bus_rd && !bus_wr) |-> !bus_doe); // R7
    AST_STATUS_FMT: assert property (@(posedge clk) disable iff (rst)
        (bus_doe && !bus_a0) |-> ((bus_dout & ~(8'h01 << RETRACE_BIT)) == '0
                                  && bus_dout[RETRACE_BIT] == retrace)); // R5
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb, par_stb, drd_stb})); // R10
endmodule

// File: tb/hbi_decoder_test.sv
module hbi_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_mode = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_a0 = 1'b0;
    logic       bus_rd = 1'b1;
    logic       bus_wr = 1'b1;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic       retrace = 1'b0;
    logic [7:0] core_rdata = 8'h00;
    logic       cmd_stb, par_stb, drd_stb, asleep;
    logic [7:0] cmd_code, par_data;

    int errors = 0;
    int checks = 0;
    int n_cmd = 0, n_par = 0, n_drd = 0;
    logic [7:0] last_cmd = 8'h00, last_par = 8'h00;
    int run_cmd = 0, run_par = 0, run_drd = 0;
    int wide_pulse = 0, overlap = 0;

    hbi_decoder uut (
        .clk(clk), .rst(rst), .bus_mode(bus_mode), .bus_cs_n(bus_cs_n),
        .bus_a0(bus_a0), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .retrace(retrace),
        .core_rdata(core_rdata), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .par_stb(par_stb), .par_data(par_data), .drd_stb(drd_stb), .asleep(asleep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_stb) begin n_cmd++; last_cmd = cmd_code; run_cmd++; end else run_cmd = 0;
            if (par_stb) begin n_par++; last_par = par_data; run_par++; end else run_par = 0;
            if (drd_stb) begin n_drd++; run_drd++; end else run_drd = 0;
            if (run_cmd > 1 || run_par > 1 || run_drd > 1) wide_pulse++;
            if (int'(cmd_stb) + int'(par_stb) + int'(drd_stb) > 1) overlap++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_release();
        bus_cs_n = 1'b1;
        bus_rd   = 1'b1;
        bus_wr   = bus_mode ? 1'b0 : 1'b1;
        idle(8);
    endtask

    task automatic do_write(input logic a, input logic [7:0] d, input logic sel);
        bus_a0   = a;
        bus_din  = d;
        bus_cs_n = ~sel;
        if (!bus_mode) begin
            bus_rd = 1'b1; bus_wr = 1'b0; idle(4);
            bus_wr = 1'b1; idle(4);
        end else begin
            bus_rd = 1'b0; bus_wr = 1'b1; idle(4);
            bus_wr = 1'b0; idle(4);
        end
        bus_release();
    endtask

    task automatic do_read(input logic a, output logic [7:0] val, output logic oe);
        bus_a0   = a;
        bus_cs_n = 1'b0;
        bus_rd   = bus_mode ? 1'b1 : 1'b0;
        bus_wr   = 1'b1;
        idle(3);
        val = bus_dout;
        oe  = bus_doe;
        bus_release();
    endtask

    task automatic t_reset();
        check("R11 doe", int'(bus_doe), 0);
        check("R11 asleep", int'(asleep), 0);
        check("R11 no strobes", n_cmd + n_par + n_drd, 0);
    endtask

    task automatic t_writes(input logic m, input string rq);
        int c0, p0;
        bus_mode = m; bus_release();
        c0 = n_cmd; p0 = n_par;
        do_write(1'b1, m ? 8'h6C : 8'h5A, 1'b1);
        check({rq, " cmd count"}, n_cmd - c0, 1);
        check({rq, " cmd code"}, int'(last_cmd), m ? 8'h6C : 8'h5A);
        do_write(1'b0, m ? 8'h3E : 8'h11, 1'b1);
        check({rq, " par count"}, n_par - p0, 1);
        check({rq, " par data"}, int'(last_par), m ? 8'h3E : 8'h11);
        check({rq, " cmd untouched by par"}, n_cmd - c0, 1);
    endtask

    task automatic t_reads(input logic m, input string rq);
        logic [7:0] v; logic oe; int d0;
        bus_mode = m; bus_release();
        retrace = 1'b1;
        do_read(1'b0, v, oe);
        check({rq, " R5 status retrace=1"}, int'(v), 8'h40);
        check({rq, " status oe"}, int'(oe), 1);
        retrace = 1'b0;
        do_read(1'b0, v, oe);
        check({rq, " R5 status retrace=0"}, int'(v), 8'h00);
        core_rdata = m ? 8'hC3 : 8'hA5;
        d0 = n_drd;
        do_read(1'b1, v, oe);
        check({rq, " data read"}, int'(v), m ? 8'hC3 : 8'hA5);
        check({rq, " data oe"}, int'(oe), 1);
        check({rq, " drd pulse"}, n_drd - d0, 1);
    endtask

    task automatic t_deselect();
        int s0;
        bus_mode = 1'b0; bus_release();
        s0 = n_cmd + n_par + n_drd;
        do_write(1'b1, 8'h77, 1'b0);
        do_write(1'b0, 8'h78, 1'b0);
        bus_cs_n = 1'b1; bus_a0 = 1'b1; bus_rd = 1'b0; bus_wr = 1'b1; idle(3);
        check("R6 doe with cs high", int'(bus_doe), 0);
        bus_release();
        check("R6 no strobes", n_cmd + n_par + n_drd - s0, 0);
    endtask

    task automatic t_both_low();
        int s0;
        bus_mode = 1'b0; bus_release();
        s0 = n_cmd + n_par + n_drd;
        bus_cs_n = 1'b0; bus_a0 = 1'b1;
        bus_rd = 1'b0; bus_wr = 1'b0; idle(5);
        check("R7 doe both low", int'(bus_doe), 0);
        bus_rd = 1'b1; bus_wr = 1'b1; idle(2);
        bus_release();
        check("R7 no strobes", n_cmd + n_par + n_drd - s0, 0);
    endtask

    task automatic t_sleep();
        int c0, p0;
        bus_mode = 1'b0; bus_release();
        c0 = n_cmd;
        do_write(1'b1, 8'h53, 1'b1);
        check("R8 sleep accepted", n_cmd - c0, 1);
        check("R8 asleep set", int'(asleep), 1);
        c0 = n_cmd;
        do_write(1'b1, 8'h22, 1'b1);
        check("R8 other cmd dropped", n_cmd - c0, 0);
        p0 = n_par;
        do_write(1'b0, 8'h33, 1'b1);
        do_write(1'b0, 8'h34, 1'b1);
        check("R9 params discarded", n_par - p0, 0);
        do_write(1'b1, 8'h53, 1'b1);
        check("R8 sleep code while asleep", n_cmd - c0, 1);
        p0 = n_par;
        do_write(1'b0, 8'h35, 1'b1);
        check("R9 param after accepted cmd", n_par - p0, 1);
        do_write(1'b1, 8'h40, 1'b1);
        check("R8 sysset accepted", n_cmd - c0, 2);
        check("R8 sysset code", int'(last_cmd), 8'h40);
        check("R8 asleep cleared", int'(asleep), 0);
        c0 = n_cmd;
        do_write(1'b1, 8'h22, 1'b1);
        check("R8 awake cmd passes", n_cmd - c0, 1);
    endtask

    initial begin : main
        idle(4);
        rst = 1'b0;
        idle(4);
        t_reset();
        t_writes(1'b0, "R1");
        t_writes(1'b1, "R2");
        t_reads(1'b0, "R3");
        t_reads(1'b1, "R4");
        t_deselect();
        t_both_low();
        t_sleep();
        check("R10 pulse width", wide_pulse, 0);
        check("R10 strobe overlap", overlap, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule